// File: doc/BRIEF.md
# Pipelined Complex Multiply-Accumulate Engine

This block sums the products of a vector of complex pairs. For every element index k, one complex operand arrives from an external memory port at address `base_addr + k`, and the other comes from a small local RAM at address `k`. Each pair is multiplied as complex numbers in signed fixed point. The real and imaginary results are added into two wide accumulators.

Work is split over two overlapping stages. A fetch stage requests the next pair while a compute stage processes the current one. The compute stage has one shared multiplier and uses it once every two cycles, so an element takes eight cycles of arithmetic: four products and four additions. When memory answers at once, the fetch of element k+1 is hidden behind the arithmetic of element k. The engine then sustains one complex multiply-accumulate every eight cycles.

The external memory read is a valid/ready handshake. The engine raises `mem_rd_valid` with an address and holds both until `mem_rd_ready` is sampled high. The read data is taken on that same edge. A low `mem_rd_ready` is back-pressure. The fetch stage waits, and the compute stage finishes the element it holds and then idles with the accumulators frozen. The local RAM port is an asynchronous read: `ram_rd_data` must reflect `ram_rd_addr` within the same cycle. The command pins and `busy`/`done` are plain level signals.

Top module: `cmac_engine`

## Requirements
- R1: After reset, `busy`, `done` and `mem_rd_valid` are low and both accumulators read zero.
- R2: Each 32-bit operand word carries the real part in bits [31:16] and the imaginary part in bits [15:0], both 16-bit two's complement. After a command, `acc_re` equals the sum of ar*br - ai*bi and `acc_im` equals the sum of ar*bi + ai*br over all elements, as 40-bit signed values. Here a is the memory operand and b is the RAM operand.
- R3: Element k is read from memory address `base_addr + k` and from RAM address `k`. Exactly `length` memory reads are accepted per command.
- R4: `start` is accepted only while `busy` is low. Acceptance clears both accumulators and `done`. A `start` while `busy` is high is ignored.
- R5: `busy` is high from the edge after an accepted start until `done` rises. `done` then stays high until the next accepted start.
- R6: With `mem_rd_ready` held high, `done` is first seen high exactly 8*length+3 clock edges after the edge that accepts `start`.
- R7: A command with `length` zero issues no memory read, leaves both accumulators at zero, and raises `done` on the first edge after acceptance.
- R8: Once `mem_rd_valid` is high, it and `mem_rd_addr` stay unchanged until `mem_rd_ready` is sampled high.
- R9: While no memory read is accepted, the compute stage completes only the element already fetched. After that, both accumulators hold their value and `done` stays low.
- R10: The final accumulator values do not depend on the timing of `mem_rd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, taken when `busy` is low |
| length | input | LEN_W (7) | Number of element pairs |
| base_addr | input | ADDR_W (16) | External address of element 0 |
| busy | output | 1 | Command in progress |
| mem_rd_valid | output | 1 | External read request valid |
| mem_rd_addr | output | ADDR_W (16) | External read address |
| mem_rd_ready | input | 1 | External read accepted; data valid on this edge |
| mem_rd_data | input | 2*DW (32) | External operand word |
| ram_rd_addr | output | RAM_AW (6) | Local RAM read address |
| ram_rd_data | input | 2*DW (32) | Local RAM operand word (asynchronous read) |
| acc_re | output | ACC_W (40) | Real accumulator |
| acc_im | output | ACC_W (40) | Imaginary accumulator |
| done | output | 1 | Command complete, held until next accepted start |

## Verification
Some internal faults never alter a single product. A phase counter that wraps wrongly, a swapped multiplier operand or a wrong sign on one accumulate step would still surface at the first `done`, as a mismatch of either accumulator. The edge count to `done` under a constant `mem_rd_ready` exposes any lost overlap between fetch and compute: each element adds eight cycles, so one missed overlap shifts `done` by at least one edge. Holding `mem_rd_ready` low after one accepted read shows any drift within about eight cycles. The accumulators must settle at exactly the first element's product, with `mem_rd_valid` still raised at an unchanged address.

// File: rtl/cmac_pkg.sv
package cmac_pkg;
  localparam int unsigned PHASE_W    = 3;
  localparam int unsigned PHASE_LAST = 7;

  typedef enum logic [1:0] {
    ST_RE_ADD = 2'd0,
    ST_RE_SUB = 2'd1,
    ST_IM_ADD = 2'd2,
    ST_IM_ADD2 = 2'd3
  } acc_step_e;

  function automatic acc_step_e step_of(input logic [PHASE_W-1:0] ph);
    return acc_step_e'(ph[2:1]);
  endfunction
endpackage

// File: rtl/cmac_fetch.sv
module cmac_fetch #(
  parameter int unsigned DW     = 16,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned RAM_AW = 6,
  parameter int unsigned LEN_W  = RAM_AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic [LEN_W-1:0]  len_in,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              take,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ready,
  input  logic [2*DW-1:0]   mem_rd_data,
  output logic [RAM_AW-1:0] ram_rd_addr,
  input  logic [2*DW-1:0]   ram_rd_data,
  output logic              hold_full,
  output logic [2*DW-1:0]   hold_a,
  output logic [2*DW-1:0]   hold_b,
  output logic              all_fetched
);
  logic [LEN_W-1:0]  idx, len_q;
  logic [ADDR_W-1:0] base_q;
  logic              fire;

  assign all_fetched  = (idx == len_q);
  assign mem_rd_valid = run && !all_fetched && !hold_full;
  assign mem_rd_addr  = base_q + ADDR_W'(idx);
  assign ram_rd_addr  = idx[RAM_AW-1:0];
  assign fire         = mem_rd_valid && mem_rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= '0;
      len_q     <= '0;
      base_q    <= '0;
      hold_full <= 1'b0;
      hold_a    <= '0;
      hold_b    <= '0;
    end else if (clear) begin
      idx       <= '0;
      len_q     <= len_in;
      base_q    <= base_in;
      hold_full <= 1'b0;
    end else begin
      if (fire) begin
        hold_a    <= mem_rd_data;
        hold_b    <= ram_rd_data;
        hold_full <= 1'b1;
        idx       <= idx + 1'b1;
      end else if (take) begin
        hold_full <= 1'b0;
      end
    end
  end

  // R8: a raised request keeps its address until accepted
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready && !clear) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R3: never more reads than the command length
  a_r3_no_overfetch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (idx < len_q));
endmodule

// File: rtl/cmac_compute.sv
module cmac_compute
  import cmac_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned ACC_W = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    hold_full,
  input  logic [2*DW-1:0]         hold_a,
  input  logic [2*DW-1:0]         hold_b,
  input  logic                    all_fetched,
  output logic                    take,
  output logic                    last_elem,
  output logic signed [ACC_W-1:0] acc_re,
  output logic signed [ACC_W-1:0] acc_im
);
  localparam int unsigned PW = 2 * DW;

  logic                   cmp_run;
  logic [PHASE_W-1:0]     phase;
  logic signed [DW-1:0]   ar, ai, br, bi, mul_x, mul_y;
  logic signed [PW-1:0]   prod;
  logic signed [ACC_W-1:0] prod_ext;
  logic                   elem_end;

  assign elem_end  = cmp_run && (phase == PHASE_W'(PHASE_LAST));
  assign take      = hold_full && (!cmp_run || elem_end) && !clear;
  assign last_elem = elem_end && all_fetched && !hold_full;

  // even phases: ar*br, ai*bi, ar*bi, ai*br
  assign mul_x    = phase[1] ? ai : ar;
  assign mul_y    = phase[2] ? (phase[1] ? br : bi) : (phase[1] ? bi : br);
  assign prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_run <= 1'b0;
      phase   <= '0;
      ar <= '0; ai <= '0; br <= '0; bi <= '0;
    end else if (clear) begin
      cmp_run <= 1'b0;
      phase   <= '0;
    end else if (take) begin
      ar <= hold_a[PW-1:DW];
      ai <= hold_a[DW-1:0];
      br <= hold_b[PW-1:DW];
      bi <= hold_b[DW-1:0];
      cmp_run <= 1'b1;
      phase   <= '0;
    end else if (cmp_run) begin
      phase <= phase + 1'b1;
      if (elem_end) cmp_run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod   <= '0;
      acc_re <= '0;
      acc_im <= '0;
    end else if (clear) begin
      acc_re <= '0;
      acc_im <= '0;
    end else if (cmp_run) begin
      if (!phase[0]) begin
        prod <= mul_x * mul_y;
      end else begin
        unique case (step_of(phase))
          ST_RE_ADD:  acc_re <= acc_re + prod_ext;
          ST_RE_SUB:  acc_re <= acc_re - prod_ext;
          ST_IM_ADD:  acc_im <= acc_im + prod_ext;
          ST_IM_ADD2: acc_im <= acc_im + prod_ext;
        endcase
      end
    end
  end

  // R9: an idle compute stage leaves the accumulators untouched
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_run && !clear) |=> ($stable(acc_re) && $stable(acc_im)));

  // R6: an element ends after phase 7 unless another pair is waiting
  a_r6_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_end && !hold_full && !clear) |=> !cmp_run);

  // R2: the real accumulator moves only on the first two odd phases
  a_r2_re_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_run && !clear && (phase[0] == 1'b0 || phase[2] == 1'b1)) |=> $stable(acc_re));
endmodule

// File: rtl/cmac_engine.sv
module cmac_engine #(
  parameter int unsigned DW     = 16,
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned RAM_AW = 6,
  localparam int unsigned LEN_W = RAM_AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  length,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              busy,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ready,
  input  logic [2*DW-1:0]   mem_rd_data,
  output logic [RAM_AW-1:0] ram_rd_addr,
  input  logic [2*DW-1:0]   ram_rd_data,
  output logic [ACC_W-1:0]  acc_re,
  output logic [ACC_W-1:0]  acc_im,
  output logic              done
);
  logic            active, done_pend, start_ok;
  logic            take, last_elem, hold_full, all_fetched;
  logic [2*DW-1:0] hold_a, hold_b;
  logic signed [ACC_W-1:0] sre, sim;

  assign busy     = active || done_pend;
  assign start_ok = start && !busy;
  assign acc_re   = sre;
  assign acc_im   = sim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      done_pend <= 1'b0;
      done      <= 1'b0;
    end else if (start_ok) begin
      active    <= (length != '0);
      done_pend <= (length == '0);
      done      <= 1'b0;
    end else begin
      if (active && last_elem) begin
        active    <= 1'b0;
        done_pend <= 1'b1;
      end
      if (done_pend) begin
        done_pend <= 1'b0;
        done      <= 1'b1;
      end
    end
  end

  cmac_fetch #(.DW(DW), .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .LEN_W(LEN_W)) u_fetch (
    .clk, .rst_n, .clear(start_ok), .run(active), .len_in(length), .base_in(base_addr),
    .take, .mem_rd_valid, .mem_rd_addr, .mem_rd_ready, .mem_rd_data,
    .ram_rd_addr, .ram_rd_data, .hold_full, .hold_a, .hold_b, .all_fetched
  );

  cmac_compute #(.DW(DW), .ACC_W(ACC_W)) u_compute (
    .clk, .rst_n, .clear(start_ok), .hold_full, .hold_a, .hold_b, .all_fetched,
    .take, .last_elem, .acc_re(sre), .acc_im(sim)
  );

  // R4: an accepted start clears done on the next edge
  a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> !done);

  // R5: done holds until a new command is accepted
  a_r5_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start_ok) |=> done);

  // R5: busy and done never overlap
  a_r5_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

// File: tb/test_cmac_engine.sv
`timescale 1ns/1ps
module test_cmac_engine;
  localparam int DW = 16, ACC_W = 40, ADDR_W = 16, RAM_AW = 6, LEN_W = RAM_AW + 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mem_rd_ready = 1'b0;
  logic [LEN_W-1:0] length = '0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic busy, mem_rd_valid, done;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [2*DW-1:0] mem_rd_data, ram_rd_data;
  logic [RAM_AW-1:0] ram_rd_addr;
  logic [ACC_W-1:0] acc_re, acc_im;

  logic [31:0] xmem [0:255];
  logic [31:0] lram [0:63];
  int n_chk = 0, n_bad = 0, cyc = 0;
  int rdy_mode = 0, grants = 0;
  int fetch_k = 0, cur_base = 0;
  logic [79:0] exp_q[$];
  int len_q[$];
  logic done_d = 1'b0, prev_stall = 1'b0;
  logic [ADDR_W-1:0] prev_addr = '0;

  always #2.5 clk = ~clk;

  assign mem_rd_data = xmem[mem_rd_addr[7:0]];
  assign ram_rd_data = lram[ram_rd_addr];

  cmac_engine i_cmac_engine (
    .clk, .rst_n, .start, .length, .base_addr, .busy, .mem_rd_valid, .mem_rd_addr,
    .mem_rd_ready, .mem_rd_data, .ram_rd_addr, .ram_rd_data, .acc_re, .acc_im, .done
  );

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [79:0] model(input int base, input int len);
    longint re = 0, im = 0;
    for (int k = 0; k < len; k++) begin
      longint ar = longint'($signed(xmem[base+k][31:16]));
      longint ai = longint'($signed(xmem[base+k][15:0]));
      longint br = longint'($signed(lram[k][31:16]));
      longint bi = longint'($signed(lram[k][15:0]));
      re += ar * br - ai * bi;
      im += ar * bi + ai * br;
    end
    return {re[39:0], im[39:0]};
  endfunction

  // ready driver, changes just after the rising edge
  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0: mem_rd_ready = 1'b1;
      1: mem_rd_ready = ($urandom % 3) == 0;
      default: mem_rd_ready = (grants > 0);
    endcase
  end

  // monitor: fetch addressing, request stability, scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) check("R8", {79'd0, mem_rd_valid && (mem_rd_addr == prev_addr)}, 80'd1);
      prev_stall = mem_rd_valid && !mem_rd_ready;
      prev_addr  = mem_rd_addr;
      if (mem_rd_valid && mem_rd_ready) begin
        check("R3", {48'd0, 16'(mem_rd_addr), 10'd0, ram_rd_addr},
              {48'd0, 16'(cur_base + fetch_k), 10'd0, 6'(fetch_k)});
        fetch_k++;
        if (grants > 0) grants--;
      end
      if (done && !done_d) begin
        if (exp_q.size() == 0) check("R5", 80'd1, 80'd0);
        else begin
          check("R2", {acc_re, acc_im}, exp_q.pop_front());
          check("R3", 80'(fetch_k), 80'(len_q.pop_front()));
        end
      end
      done_d = done;
    end
  end

  task automatic start_cmd(input int base, input int len);
    @(negedge clk);
    while (busy) @(negedge clk);
    exp_q.push_back(model(base, len));
    len_q.push_back(len);
    fetch_k = 0; cur_base = base;
    base_addr = ADDR_W'(base); length = LEN_W'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cnt);
    cnt = 0;
    while (!done) begin cnt++; @(negedge clk); end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int c;
    for (int i = 0; i < 256; i++) xmem[i] = $urandom;
    for (int i = 0; i < 64; i++) lram[i] = $urandom;
    xmem[20] = 32'h8000_8000; lram[0] = 32'h8000_7FFF;
    repeat (3) @(negedge clk);
    check("R1", {76'd0, busy, done, mem_rd_valid, 1'b0}, 80'd0);
    check("R1", {acc_re, acc_im}, 80'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 throughput, R2 sign extremes (base 20 holds -32768 parts)
    start_cmd(20, 1); wait_done(c); check("R6", 80'(c), 80'(8 * 1 + 3));
    start_cmd(5, 4);  wait_done(c); check("R6", 80'(c), 80'(8 * 4 + 3));
    start_cmd(100, 64); wait_done(c); check("R6", 80'(c), 80'(8 * 64 + 3));

    // R7 zero length
    start_cmd(30, 0); wait_done(c);
    check("R7", 80'(c), 80'd1);
    check("R7", {acc_re, acc_im}, 80'd0);

    // R4 start while busy is ignored; R5 busy during command
    start_cmd(10, 5);
    repeat (5) @(negedge clk);
    check("R5", 80'(busy), 80'd1);
    base_addr = 16'd150; length = 7'd2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(c);
    check("R4", 80'(c), 80'(8 * 5 + 3 - 6));
    repeat (4) @(negedge clk);
    check("R5", {78'd0, done, busy}, 80'd2);

    // R10 random back-pressure
    rdy_mode = 1;
    start_cmd(40, 7);  wait_done(c);
    start_cmd(60, 33); wait_done(c);
    start_cmd(0, 64);  wait_done(c);

    // R9 stall after one accepted read
    rdy_mode = 2; grants = 1;
    start_cmd(70, 3);
    repeat (30) @(negedge clk);
    check("R9", {acc_re, acc_im}, model(70, 1));
    check("R9", {77'd0, done, busy, mem_rd_valid}, 80'd3);
    grants = 100;
    wait_done(c);
    rdy_mode = 0;
    repeat (3) @(negedge clk);
    check("R10", 80'(exp_q.size()), 80'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule